// File: doc/BRIEF.md
# Match-Action Table Lookup

This block keeps a table of match entries that a control-plane write port fills in while the chip runs. Each entry has a valid flag, a key, a mask, an action identifier and a word of action data. The data path presents one packet-header word per cycle. The block takes the lookup key as a fixed slice of that word, compares the key with every valid entry in parallel, and a fixed number of cycles later returns hit or miss together with an action identifier and its data.

The match kind is set per instance by a parameter. In exact mode every key bit must be equal. In ternary mode a stored mask chooses which bits are compared. In longest-prefix mode a stored prefix length chooses how many leading key bits are compared. When several entries match, the entry with the lowest index wins. For longest-prefix use, the control plane is expected to store entries sorted from longest prefix to shortest. A miss returns a default action and default data, which are written through the same port. An instance built without a key always returns the default.

Top module: `mat_lookup`

## Requirements
- R1: A request accepted with `lk_valid` high on a clock edge produces `rs_valid` high, with its result, exactly two edges later. A new request can be accepted on every edge. `rs_valid` is low in any cycle that has no matching request.
- R2: The key is `lk_hdr[KEY_OFS +: KEY_W]`. Header bits outside that slice have no effect on the result.
- R3: With `MATCH_KIND` = 0 (exact), an entry matches only when all `KEY_W` bits equal its stored key.
- R4: With `MATCH_KIND` = 1 (ternary), an entry matches when the key equals the stored key on every bit where the stored mask `cp_mask` is 1. Bits where the mask is 0 are ignored.
- R5: With `MATCH_KIND` = 2 (longest-prefix), an entry matches when the key equals the stored key on its top `cp_plen` bits. `cp_plen` values of `KEY_W` or more compare all bits, and `cp_mask` is ignored.
- R6: When more than one valid entry matches, the result carries the action and data of the entry with the lowest index.
- R7: On a miss, `rs_hit` is 0 and `rs_act`/`rs_data` carry the default action and default data. On a hit, `rs_hit` is 1 and they carry the matching entry's action and data.
- R8: An entry written with `cp_valid` = 0 never matches. Writing it that way removes it from the table.
- R9: With `KEY_EN` = 0, every result is a miss that carries the default action and data, whatever the header.
- R10: A lookup sees every entry and default write made on or before the edge that accepted it, and none made on a later edge. Every field of an entry changes together.
- R11: After reset, `rs_valid` and `rs_hit` are 0, every entry is invalid, and the default action and data are 0.
- R12: A write with `cp_def_we` = 1 sets the default action to `cp_act` and the default data to `cp_data`, following the timing of R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_hdr | input | HDR_W | Header word that holds the key |
| rs_valid | output | 1 | Result valid |
| rs_hit | output | 1 | 1 = an entry matched |
| rs_act | output | ACT_W | Action identifier |
| rs_data | output | DATA_W | Action data |
| cp_we | input | 1 | Entry write strobe |
| cp_addr | input | $clog2(DEPTH) | Entry index to write |
| cp_valid | input | 1 | Valid flag for the written entry |
| cp_key | input | KEY_W | Key for the written entry |
| cp_mask | input | KEY_W | Care mask (ternary mode) |
| cp_plen | input | $clog2(KEY_W+1) | Prefix length (longest-prefix mode) |
| cp_act | input | ACT_W | Action identifier for the entry or the default |
| cp_data | input | DATA_W | Action data for the entry or the default |
| cp_def_we | input | 1 | Write strobe for the default action and data |

## Verification
The same header sequence goes to four instances at once: exact, ternary, longest-prefix and keyless. One stored table then yields different results per mode. A key that differs only in its low nibble hits the ternary and prefix instances but misses the exact one. A key that differs only on a masked middle bit separates ternary matching from prefix matching. Keys that several entries match check that the lowest index wins, including after the winning entry has been invalidated. Headers whose non-key bits vary, and a header whose key sits at the wrong offset, show that only the key slice matters. Writes issued on the accepting edge and on the edge after it show which table state a lookup sees.

// File: rtl/mat_lookup.sv
module mat_lookup #(
  parameter int DEPTH      = 1024,
  parameter int KEY_W      = 32,
  parameter int HDR_W      = 64,
  parameter int KEY_OFS    = 0,
  parameter int ACT_W      = 8,
  parameter int DATA_W     = 32,
  parameter int MATCH_KIND = 1,
  parameter int KEY_EN     = 1,
  localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int PL_W      = $clog2(KEY_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [HDR_W-1:0]  lk_hdr,
  output logic              rs_valid,
  output logic              rs_hit,
  output logic [ACT_W-1:0]  rs_act,
  output logic [DATA_W-1:0] rs_data,
  input  logic              cp_we,
  input  logic [IDX_W-1:0]  cp_addr,
  input  logic              cp_valid,
  input  logic [KEY_W-1:0]  cp_key,
  input  logic [KEY_W-1:0]  cp_mask,
  input  logic [PL_W-1:0]   cp_plen,
  input  logic [ACT_W-1:0]  cp_act,
  input  logic [DATA_W-1:0] cp_data,
  input  logic              cp_def_we
);

  logic [KEY_W-1:0]  t_key [DEPTH];
  logic [KEY_W-1:0]  t_msk [DEPTH];
  logic [ACT_W-1:0]  t_act [DEPTH];
  logic [DATA_W-1:0] t_dat [DEPTH];
  logic [DEPTH-1:0]  t_vld;
  logic [ACT_W-1:0]  def_act;
  logic [DATA_W-1:0] def_dat;

  logic              s1_v;
  logic [KEY_W-1:0]  s1_k;
  logic              any_c;
  logic [IDX_W-1:0]  idx_c;
  logic [KEY_W-1:0]  wr_msk;
  logic [KEY_W-1:0]  pfx_msk;
  logic              unused_hdr;

  assign unused_hdr = ^lk_hdr;

  assign pfx_msk = (cp_plen >= PL_W'(KEY_W)) ? {KEY_W{1'b1}}
                                             : ~({KEY_W{1'b1}} >> cp_plen);
  assign wr_msk  = (MATCH_KIND == 0) ? {KEY_W{1'b1}} :
                   (MATCH_KIND == 1) ? cp_mask : pfx_msk;

  always_ff @(posedge clk) begin
    if (cp_we) begin
      t_key[cp_addr] <= cp_key;
      t_msk[cp_addr] <= wr_msk;
      t_act[cp_addr] <= cp_act;
      t_dat[cp_addr] <= cp_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_vld   <= '0;
      def_act <= '0;
      def_dat <= '0;
    end else begin
      if (cp_we) t_vld[cp_addr] <= cp_valid;
      if (cp_def_we) begin
        def_act <= cp_act;
        def_dat <= cp_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_k <= '0;
    end else begin
      s1_v <= lk_valid;
      s1_k <= lk_hdr[KEY_OFS +: KEY_W];
    end
  end

  always_comb begin
    any_c = 1'b0;
    idx_c = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (t_vld[i] && (((s1_k ^ t_key[i]) & t_msk[i]) == '0)) begin
        any_c = 1'b1;
        idx_c = IDX_W'(i);
      end
    end
    if (KEY_EN == 0) any_c = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_hit   <= 1'b0;
      rs_act   <= '0;
      rs_data  <= '0;
    end else begin
      rs_valid <= s1_v;
      rs_hit   <= s1_v && any_c;
      rs_act   <= any_c ? t_act[idx_c] : def_act;
      rs_data  <= any_c ? t_dat[idx_c] : def_dat;
    end
  end

  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> ##1 rs_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> ##1 !rs_valid);
  a_r7_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rs_valid |-> !rs_hit);
  a_r8_empty_misses: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && $past(t_vld == '0)) |-> !rs_hit);

  generate
    if (KEY_EN == 0) begin : g_nokey
      a_r9_keyless_miss: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> !rs_hit);
    end
  endgenerate

endmodule

// File: tb/mat_lookup_bench.sv
module mat_lookup_bench;
  localparam int KW = 16, HW = 32, KO = 8, AW = 4, DW = 8, DP = 16, IW = 4, PW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 1'b0;
  logic [HW-1:0] lk_hdr = '0;
  logic cp_we = 1'b0, cp_valid = 1'b0, cp_def_we = 1'b0;
  logic [IW-1:0] cp_addr = '0;
  logic [KW-1:0] cp_key = '0, cp_mask = '0;
  logic [PW-1:0] cp_plen = '0;
  logic [AW-1:0] cp_act = '0;
  logic [DW-1:0] cp_data = '0;

  logic [3:0] v, h;
  logic [AW-1:0] a [4];
  logic [DW-1:0] d [4];

  logic [AW-1:0] def_a = '0;
  logic [DW-1:0] def_d = '0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  mat_lookup #(.DEPTH(DP), .KEY_W(KW), .HDR_W(HW), .KEY_OFS(KO), .ACT_W(AW), .DATA_W(DW),
               .MATCH_KIND(1), .KEY_EN(1)) u_mat_lookup (
    .clk, .rst_n, .lk_valid, .lk_hdr, .rs_valid(v[1]), .rs_hit(h[1]), .rs_act(a[1]),
    .rs_data(d[1]), .cp_we, .cp_addr, .cp_valid, .cp_key, .cp_mask, .cp_plen, .cp_act,
    .cp_data, .cp_def_we);
  mat_lookup #(.DEPTH(DP), .KEY_W(KW), .HDR_W(HW), .KEY_OFS(KO), .ACT_W(AW), .DATA_W(DW),
               .MATCH_KIND(0), .KEY_EN(1)) u_exact (
    .clk, .rst_n, .lk_valid, .lk_hdr, .rs_valid(v[0]), .rs_hit(h[0]), .rs_act(a[0]),
    .rs_data(d[0]), .cp_we, .cp_addr, .cp_valid, .cp_key, .cp_mask, .cp_plen, .cp_act,
    .cp_data, .cp_def_we);
  mat_lookup #(.DEPTH(DP), .KEY_W(KW), .HDR_W(HW), .KEY_OFS(KO), .ACT_W(AW), .DATA_W(DW),
               .MATCH_KIND(2), .KEY_EN(1)) u_lpm (
    .clk, .rst_n, .lk_valid, .lk_hdr, .rs_valid(v[2]), .rs_hit(h[2]), .rs_act(a[2]),
    .rs_data(d[2]), .cp_we, .cp_addr, .cp_valid, .cp_key, .cp_mask, .cp_plen, .cp_act,
    .cp_data, .cp_def_we);
  mat_lookup #(.DEPTH(DP), .KEY_W(KW), .HDR_W(HW), .KEY_OFS(KO), .ACT_W(AW), .DATA_W(DW),
               .MATCH_KIND(1), .KEY_EN(0)) u_nokey (
    .clk, .rst_n, .lk_valid, .lk_hdr, .rs_valid(v[3]), .rs_hit(h[3]), .rs_act(a[3]),
    .rs_data(d[3]), .cp_we, .cp_addr, .cp_valid, .cp_key, .cp_mask, .cp_plen, .cp_act,
    .cp_data, .cp_def_we);

  // {header, exact code, ternary code, prefix code}; code = {hit, index}
  localparam logic [46:0] VEC [13] = '{
    {32'h5A1234C3, 5'h10, 5'h10, 5'h10},
    {32'h001235FF, 5'h00, 5'h11, 5'h11},
    {32'h77129901, 5'h00, 5'h12, 5'h12},
    {32'h01120002, 5'h12, 5'h12, 5'h12},
    {32'hFF123000, 5'h11, 5'h11, 5'h11},
    {32'h3C80003C, 5'h13, 5'h13, 5'h13},
    {32'h009ABC00, 5'h00, 5'h13, 5'h13},
    {32'h81567818, 5'h14, 5'h14, 5'h14},
    {32'h00000000, 5'h00, 5'h00, 5'h00},
    {32'h00567900, 5'h00, 5'h00, 5'h00},
    {32'h0034F700, 5'h00, 5'h15, 5'h00},
    {32'h0000F000, 5'h15, 5'h15, 5'h15},
    {32'h00001234, 5'h00, 5'h00, 5'h00}
  };

  task automatic chk(input string req, input int u, input logic [4:0] code);
    logic [AW-1:0] ea;
    logic [DW-1:0] ed;
    ea = code[4] ? code[3:0] : def_a;
    ed = code[4] ? (8'hA0 + {4'h0, code[3:0]}) : def_d;
    n_chk++;
    if (v[u] !== 1'b1 || h[u] !== code[4] || a[u] !== ea || d[u] !== ed) begin
      n_bad++;
      $display("FAIL %s dut%0d: got v=%b h=%b a=%h d=%h, expected v=1 h=%b a=%h d=%h",
               req, u, v[u], h[u], a[u], d[u], code[4], ea, ed);
    end
  endtask

  task automatic chk_all(input string req, input logic [4:0] ce, input logic [4:0] ct,
                         input logic [4:0] cl);
    chk(req, 0, ce);
    chk(req, 1, ct);
    chk(req, 2, cl);
    chk({req, "/R9"}, 3, 5'h00);
  endtask

  task automatic wr(input int idx, input logic vl, input logic [KW-1:0] k,
                    input logic [KW-1:0] m, input logic [PW-1:0] pl);
    @(negedge clk);
    cp_we = 1'b1; cp_addr = IW'(idx); cp_valid = vl; cp_key = k; cp_mask = m;
    cp_plen = pl; cp_act = AW'(idx); cp_data = 8'hA0 + 8'(idx);
    @(negedge clk);
    cp_we = 1'b0;
  endtask

  task automatic set_def(input logic [AW-1:0] da, input logic [DW-1:0] dd);
    @(negedge clk);
    cp_def_we = 1'b1; cp_act = da; cp_data = dd;
    @(negedge clk);
    cp_def_we = 1'b0;
    def_a = da; def_d = dd;
  endtask

  task automatic look(input logic [HW-1:0] hd);
    @(negedge clk);
    lk_valid = 1'b1; lk_hdr = hd;
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #400us;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got no finish, expected finish before timeout");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    n_chk++;
    if (v !== 4'b0000 || h !== 4'b0000) begin
      n_bad++;
      $display("FAIL R11 reset: got v=%b h=%b, expected 0000 0000", v, h);
    end
    rst_n = 1'b1;
    look(32'h00123400);
    chk_all("R11 empty table", 5'h00, 5'h00, 5'h00);

    // R12: default action
    set_def(4'hF, 8'hEE);
    wr(0, 1'b1, 16'h1234, 16'hFFFF, 5'd16);
    wr(1, 1'b1, 16'h1230, 16'hFFF0, 5'd12);
    wr(2, 1'b1, 16'h1200, 16'hFF00, 5'd8);
    wr(3, 1'b1, 16'h8000, 16'h8000, 5'd1);
    wr(4, 1'b1, 16'h5678, 16'hFFFF, 5'd16);
    wr(5, 1'b1, 16'h00F0, 16'h00F0, 5'd16);

    // R2 R3 R4 R5 R6 R7: vector table
    for (int i = 0; i < 13; i++) begin
      look(VEC[i][46:15]);
      chk_all("R2/R3/R4/R5/R6/R7 vector", VEC[i][14:10], VEC[i][9:5], VEC[i][4:0]);
    end

    // R1: back-to-back requests
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (i >= 2) chk("R1 back-to-back", 1, (i == 2) ? 5'h10 : (i == 3) ? 5'h14 : 5'h12);
      if (i < 3) begin
        lk_valid = 1'b1;
        lk_hdr = (i == 0) ? 32'h00123400 : (i == 1) ? 32'h00567800 : 32'h00120000;
      end else lk_valid = 1'b0;
    end
    @(negedge clk);
    n_chk++;
    if (v !== 4'b0000) begin
      n_bad++;
      $display("FAIL R1 idle: got v=%b, expected 0000", v);
    end

    // R8: invalidated entry 0 falls through to entry 1
    wr(0, 1'b0, 16'h1234, 16'hFFFF, 5'd16);
    look(32'h00123400);
    chk_all("R8 invalidated", 5'h00, 5'h11, 5'h11);

    // R10: a write on the accepting edge is seen
    @(negedge clk);
    lk_valid = 1'b1; lk_hdr = 32'h00567900;
    cp_we = 1'b1; cp_addr = 4'd6; cp_valid = 1'b1; cp_key = 16'h5679; cp_mask = 16'hFFFF;
    cp_plen = 5'd16; cp_act = 4'd6; cp_data = 8'hA6;
    @(negedge clk);
    lk_valid = 1'b0; cp_we = 1'b0;
    @(negedge clk);
    chk_all("R10 same edge", 5'h16, 5'h16, 5'h16);

    // R10: a write one edge later is not seen
    @(negedge clk);
    lk_valid = 1'b1; lk_hdr = 32'h00111100;
    @(negedge clk);
    lk_valid = 1'b0;
    cp_we = 1'b1; cp_addr = 4'd7; cp_valid = 1'b1; cp_key = 16'h1111; cp_mask = 16'hFFFF;
    cp_plen = 5'd16; cp_act = 4'd7; cp_data = 8'hA7;
    @(negedge clk);
    cp_we = 1'b0;
    chk_all("R10 later edge", 5'h00, 5'h00, 5'h00);
    look(32'h00111100);
    chk_all("R10 after write", 5'h17, 5'h17, 5'h17);

    // R12: new default on a miss
    set_def(4'h9, 8'h5B);
    look(32'h00000000);
    chk_all("R12 new default", 5'h00, 5'h00, 5'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule